// File: doc/BRIEF.md
# Double-Edge Byte-Masked SRAM Write Port

This block models the write side of a static memory whose read and write ports are separate. It runs from a pair of complementary clocks, `clk_k` and `clk_kn`. A write spreads over both clock edges. On a rising edge of `clk_k`, an active-low select starts the write and the first 18-bit half is taken. On the rising edge of `clk_kn` that follows, the address and the second 18-bit half are taken. Each half carries its own active-low byte mask, with one bit for each 9-bit lane.

The two halves, the address and the four lane enables are held in a pending register. The merged 36-bit word is written into the array on the next rising edge of `clk_k`, and only the enabled lanes change. The pending register is brought out so that a companion read port can forward data that has not yet been written. A combinational read tap on the array lets the read side, and the bench, see the stored words. The port can issue a write on every `clk_k` cycle.

Top module: `qdr_wr_port`

## Requirements
- R1: A write starts only when `wps_n` is sampled low on a rising edge of `clk_k`. On that same edge, `din` is taken as the low half, bits [17:0] of the word, and `bws_n` is taken as the low-half mask.
- R2: On the next rising edge of `clk_kn`, `wr_addr` is taken as the address, `din` as the high half (bits [35:18]) and `bws_n` as the high-half mask.
- R3: The byte selects are active low. Bit 0 controls bits [8:0] of its half and bit 1 controls bits [17:9]. Word lanes are lane0=[8:0], lane1=[17:9], lane2=[26:18] and lane3=[35:27].
- R4: A lane whose select was high when it was sampled keeps its stored value. Only lanes that were enabled take new data.
- R5: The array changes on the `clk_k` rising edge that follows the `clk_kn` capture, and not earlier.
- R6: `pend_valid` is high from the `clk_kn` capture until the committing `clk_k` edge. During that time `pend_addr`, `pend_data` and `pend_lanes` hold the address, the word and the lane enables. `pend_lanes` bit n is the enable for lane n and is 1 when that lane is written.
- R7: `wps_n` is never sampled on `clk_kn`. A low pulse of `wps_n` that covers only a `clk_kn` edge starts no write.
- R8: While the port is deselected, `wr_addr`, `din` and `bws_n` are ignored. The pending contents stay the same and the array is unchanged.
- R9: A write that has started completes even if `wps_n` goes high right after its starting edge.
- R10: Writes may start on consecutive `clk_k` edges, including to the same address. The later write merges over the result of the earlier one.
- R11: While `rst_n` is low, `pend_valid` is 0 and every array word is cleared to zero.
- R12: `rd_data` shows, combinationally, the array word at `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_k | input | 1 | Main clock. Starts writes, takes the low half and commits to the array |
| clk_kn | input | 1 | Complementary clock. Takes the address and the high half |
| rst_n | input | 1 | Asynchronous active-low reset |
| wps_n | input | 1 | Active-low write select, sampled on `clk_k` only |
| wr_addr | input | AW | Write address, sampled on `clk_kn` |
| din | input | 18 | Write data half |
| bws_n | input | 2 | Active-low byte selects for the current half |
| rd_addr | input | AW | Array read tap address |
| rd_data | output | 36 | Array word at `rd_addr` |
| pend_valid | output | 1 | A captured write is waiting for commit |
| pend_addr | output | AW | Address of the waiting write |
| pend_data | output | 36 | Merged word of the waiting write |
| pend_lanes | output | 4 | Lane enables of the waiting write |

## Verification
The bench sweeps every address, and across those writes it covers all sixteen combinations of the two half masks. This catches swapped or inverted lanes: such a design would write the wrong 9-bit lanes, and the final array readback would disagree with the arithmetic model. Right after each `clk_kn` capture, the bench reads the target word and expects the old value. A design that commits early, or that takes the address on `clk_k`, fails that check. Further checks cover deselected cycles with changing inputs, a select pulse that covers only a `clk_kn` edge, fully masked writes, and back-to-back writes to one address. These expose a design that samples the select on both edges, lets idle inputs disturb the pending register, or loses the merge between consecutive writes.

// File: rtl/qdr_wr_pkg.sv
package qdr_wr_pkg;
    localparam int DEF_DEPTH     = 256;
    localparam int DEF_HALF_W    = 18;
    localparam int DEF_LANES_PER = 2;
endpackage

// File: rtl/qdr_wr_kside.sv
module qdr_wr_kside #(
    parameter int HALF_W = 18,
    parameter int LPH    = 2
) (
    input  logic              clk_k,
    input  logic              rst_n,
    input  logic              wps_n,
    input  logic [HALF_W-1:0] din,
    input  logic [LPH-1:0]    bws_n,
    input  logic              pend_valid,
    output logic              start_q,
    output logic [HALF_W-1:0] lo_data_q,
    output logic [LPH-1:0]    lo_en_q,
    output logic              commit_tog_q
);
    typedef struct packed {
        logic              start;
        logic [HALF_W-1:0] lo;
        logic [LPH-1:0]    lo_en;
        logic              commit_tog;
    } k_state_t;

    k_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.start = !wps_n;
        if (!wps_n) begin
            s_d.lo    = din;
            s_d.lo_en = ~bws_n;
        end
        if (pend_valid) begin
            s_d.commit_tog = ~s_q.commit_tog;
        end
    end

    always_ff @(posedge clk_k or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign start_q      = s_q.start;
    assign lo_data_q    = s_q.lo;
    assign lo_en_q      = s_q.lo_en;
    assign commit_tog_q = s_q.commit_tog;
endmodule

// File: rtl/qdr_wr_knside.sv
module qdr_wr_knside #(
    parameter int HALF_W = 18,
    parameter int LPH    = 2,
    parameter int AW     = 8
) (
    input  logic                clk_kn,
    input  logic                rst_n,
    input  logic                start_q,
    input  logic [HALF_W-1:0]   lo_data_q,
    input  logic [LPH-1:0]      lo_en_q,
    input  logic [AW-1:0]       wr_addr,
    input  logic [HALF_W-1:0]   din,
    input  logic [LPH-1:0]      bws_n,
    output logic                pend_tog_q,
    output logic [AW-1:0]       pend_addr_q,
    output logic [2*HALF_W-1:0] pend_data_q,
    output logic [2*LPH-1:0]    pend_lanes_q
);
    typedef struct packed {
        logic                tog;
        logic [AW-1:0]       addr;
        logic [2*HALF_W-1:0] data;
        logic [2*LPH-1:0]    lanes;
    } kn_state_t;

    kn_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (start_q) begin
            s_d.addr  = wr_addr;
            s_d.data  = {din, lo_data_q};
            s_d.lanes = {~bws_n, lo_en_q};
            s_d.tog   = ~s_q.tog;
        end
    end

    always_ff @(posedge clk_kn or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_tog_q   = s_q.tog;
    assign pend_addr_q  = s_q.addr;
    assign pend_data_q  = s_q.data;
    assign pend_lanes_q = s_q.lanes;
endmodule

// File: rtl/qdr_wr_array.sv
module qdr_wr_array #(
    parameter int DEPTH  = 256,
    parameter int LANE_W = 9,
    parameter int NLANES = 4,
    parameter int AW     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            waddr,
    input  logic [NLANES*LANE_W-1:0] wdata,
    input  logic [NLANES-1:0]        wlanes,
    input  logic [AW-1:0]            raddr,
    output logic [NLANES*LANE_W-1:0] rdata
);
    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane_mem_q [DEPTH];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < DEPTH; i++) lane_mem_q[i] <= '0;
            end else if (we && wlanes[l]) begin
                lane_mem_q[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        assign rdata[l*LANE_W +: LANE_W] = lane_mem_q[raddr];
    end
endmodule

// File: rtl/qdr_wr_port.sv
module qdr_wr_port
    import qdr_wr_pkg::*;
#(
    parameter int DEPTH  = DEF_DEPTH,
    parameter int HALF_W = DEF_HALF_W,
    parameter int LPH    = DEF_LANES_PER,
    localparam int AW     = $clog2(DEPTH),
    localparam int WORD_W = 2 * HALF_W,
    localparam int NLANES = 2 * LPH,
    localparam int LANE_W = HALF_W / LPH
) (
    input  logic              clk_k,
    input  logic              clk_kn,
    input  logic              rst_n,
    input  logic              wps_n,
    input  logic [AW-1:0]     wr_addr,
    input  logic [HALF_W-1:0] din,
    input  logic [LPH-1:0]    bws_n,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              pend_valid,
    output logic [AW-1:0]     pend_addr,
    output logic [WORD_W-1:0] pend_data,
    output logic [NLANES-1:0] pend_lanes
);
    logic              start_q;
    logic [HALF_W-1:0] lo_data_q;
    logic [LPH-1:0]    lo_en_q;
    logic              commit_tog_q;
    logic              pend_tog_q;

    // pending is outstanding while the two toggles disagree
    assign pend_valid = pend_tog_q ^ commit_tog_q;

    qdr_wr_kside #(.HALF_W(HALF_W), .LPH(LPH)) i_kside (
        .clk_k       (clk_k),
        .rst_n       (rst_n),
        .wps_n       (wps_n),
        .din         (din),
        .bws_n       (bws_n),
        .pend_valid  (pend_valid),
        .start_q     (start_q),
        .lo_data_q   (lo_data_q),
        .lo_en_q     (lo_en_q),
        .commit_tog_q(commit_tog_q)
    );

    qdr_wr_knside #(.HALF_W(HALF_W), .LPH(LPH), .AW(AW)) i_knside (
        .clk_kn      (clk_kn),
        .rst_n       (rst_n),
        .start_q     (start_q),
        .lo_data_q   (lo_data_q),
        .lo_en_q     (lo_en_q),
        .wr_addr     (wr_addr),
        .din         (din),
        .bws_n       (bws_n),
        .pend_tog_q  (pend_tog_q),
        .pend_addr_q (pend_addr),
        .pend_data_q (pend_data),
        .pend_lanes_q(pend_lanes)
    );

    qdr_wr_array #(.DEPTH(DEPTH), .LANE_W(LANE_W), .NLANES(NLANES), .AW(AW)) i_array (
        .clk   (clk_k),
        .rst_n (rst_n),
        .we    (pend_valid),
        .waddr (pend_addr),
        .wdata (pend_data),
        .wlanes(pend_lanes),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/qdr_wr_port_chk.sv
module qdr_wr_port_chk #(
    parameter int AW     = 8,
    parameter int WORD_W = 36
) (
    input logic              clk_k,
    input logic              clk_kn,
    input logic              rst_n,
    input logic              wps_n,
    input logic              pend_valid,
    input logic [AW-1:0]     pend_addr,
    input logic [WORD_W-1:0] pend_data
);
    // R6 / R9: a started write is pending by the next clk_k edge
    p_start_pends_r6: assert property (@(posedge clk_k) disable iff (!rst_n)
        !wps_n |=> pend_valid);

    // R8: no start means nothing pending at the next clk_k edge
    p_idle_no_pend_r8: assert property (@(posedge clk_k) disable iff (!rst_n)
        wps_n |=> !pend_valid);

    // R8: deselected cycle leaves pending contents unchanged
    p_idle_holds_r8: assert property (@(posedge clk_k) disable iff (!rst_n)
        wps_n |=> ($stable(pend_addr) && $stable(pend_data)));

    // R5: every pending write is retired by the clk_k edge before the next clk_kn
    p_retired_r5: assert property (@(posedge clk_kn) disable iff (!rst_n)
        !pend_valid);
endmodule

bind qdr_wr_port qdr_wr_port_chk #(.AW(AW), .WORD_W(WORD_W)) i_chk (
    .clk_k     (clk_k),
    .clk_kn    (clk_kn),
    .rst_n     (rst_n),
    .wps_n     (wps_n),
    .pend_valid(pend_valid),
    .pend_addr (pend_addr),
    .pend_data (pend_data)
);

// File: tb/test_qdr_wr_port.sv
`timescale 1ns/1ps
module test_qdr_wr_port;
    logic        clk_k = 1'b0;
    logic        clk_kn;
    logic        rst_n = 1'b0;
    logic        wps_n = 1'b1;
    logic [7:0]  wr_addr = '0;
    logic [17:0] din = '0;
    logic [1:0]  bws_n = 2'b11;
    logic [7:0]  rd_addr = '0;
    logic [35:0] rd_data;
    logic        pend_valid;
    logic [7:0]  pend_addr;
    logic [35:0] pend_data;
    logic [3:0]  pend_lanes;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [35:0] shadow [256];
    logic [7:0]  last_pa = '0;

    always #2.5 clk_k = ~clk_k;   // 200 MHz
    assign clk_kn = ~clk_k;

    qdr_wr_port i_qdr_wr_port (
        .clk_k(clk_k), .clk_kn(clk_kn), .rst_n(rst_n), .wps_n(wps_n),
        .wr_addr(wr_addr), .din(din), .bws_n(bws_n), .rd_addr(rd_addr),
        .rd_data(rd_data), .pend_valid(pend_valid), .pend_addr(pend_addr),
        .pend_data(pend_data), .pend_lanes(pend_lanes)
    );

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [35:0] merge(input logic [35:0] old, input logic [17:0] lo, hi,
                                          input logic [1:0] blo, bhi);
        logic [35:0] w;
        w = old;
        if (!blo[0]) w[8:0]   = lo[8:0];
        if (!blo[1]) w[17:9]  = lo[17:9];
        if (!bhi[0]) w[26:18] = hi[8:0];
        if (!bhi[1]) w[35:27] = hi[17:9];
        return w;
    endfunction

    task automatic read_chk(input logic [7:0] a, input string req);
        rd_addr = a;
        #0.1;
        chk(rd_data === shadow[a], req, rd_data, shadow[a]);
    endtask

    // entered and left 1 ns after a clk_kn rise
    task automatic wr(input logic [7:0] a, input logic [17:0] lo, hi, input logic [1:0] blo, bhi);
        wps_n = 1'b0; din = lo; bws_n = blo;
        @(posedge clk_k); #1;
        wps_n = 1'b1; din = hi; wr_addr = a; bws_n = bhi;   // R9: deselect right after start
        @(posedge clk_kn); #1;
        chk(pend_valid === 1'b1, "R6 pend_valid", {35'd0, pend_valid}, 36'd1);
        chk(pend_addr === a, "R2 address", {28'd0, pend_addr}, {28'd0, a});
        chk(pend_data[17:0] === lo, "R1 low half", {18'd0, pend_data[17:0]}, {18'd0, lo});
        chk(pend_data[35:18] === hi, "R2 high half", {18'd0, pend_data[35:18]}, {18'd0, hi});
        chk(pend_lanes === ~{bhi, blo}, "R3 lanes", {32'd0, pend_lanes}, {32'd0, ~{bhi, blo}});
        read_chk(a, "R5 not yet committed");
        shadow[a] = merge(shadow[a], lo, hi, blo, bhi);
        last_pa = a;
    endtask

    task automatic idle(input logic [7:0] junk);
        wps_n = 1'b1; din = {junk, 10'h2A5}; bws_n = 2'b00; wr_addr = junk;
        @(posedge clk_k); #1;
        din = ~din; wr_addr = ~junk;
        read_chk(last_pa, "R5 committed");
        @(posedge clk_kn); #1;
        chk(pend_valid === 1'b0, "R8 no pending", {35'd0, pend_valid}, 36'd0);
        chk(pend_addr === last_pa, "R8 pending held", {28'd0, pend_addr}, {28'd0, last_pa});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = '0;
        repeat (3) @(posedge clk_kn);
        #1;
        // R11 reset state
        chk(pend_valid === 1'b0, "R11 reset pending", {35'd0, pend_valid}, 36'd0);
        read_chk(8'd0, "R11 reset array");
        read_chk(8'd255, "R11 reset array");
        rst_n = 1'b1;
        @(posedge clk_kn); #1;

        // R3 R4 sweep: every address, all 16 mask combinations
        for (int a = 0; a < 256; a++) begin
            wr(8'(a), 18'(a * 769 + 3), 18'(a * 1543) ^ 18'h2AAAA,
               2'(a), 2'(a >> 2));
        end
        idle(8'h11);
        for (int a = 0; a < 256; a++) read_chk(8'(a), "R12 R4 sweep readback");

        // R10 back-to-back writes to one address with merging
        wr(8'd5, 18'h3FFFF, 18'h3FFFF, 2'b00, 2'b00);
        wr(8'd5, 18'h00123, 18'h01234, 2'b01, 2'b10);
        wr(8'd5, 18'h15555, 18'h2AAAA, 2'b10, 2'b01);
        wr(8'd6, 18'h0BEEF, 18'h0CAFE, 2'b00, 2'b00);
        idle(8'h22);
        read_chk(8'd5, "R10 merged word");
        read_chk(8'd6, "R10 following write");

        // R4 fully masked write leaves word unchanged
        wr(8'd9, 18'h3FFFF, 18'h3FFFF, 2'b11, 2'b11);
        idle(8'd9);
        read_chk(8'd9, "R4 masked write");

        // R8 deselected cycles with active-looking inputs
        for (int j = 0; j < 4; j++) idle(8'(40 + j));
        for (int j = 0; j < 4; j++) begin
            read_chk(8'(40 + j), "R8 array untouched");
            read_chk(~8'(40 + j), "R8 array untouched");
        end

        // R7 select low only around a clk_kn edge
        @(posedge clk_k); #1;
        wps_n = 1'b0; wr_addr = 8'd77; din = 18'h3FFFF; bws_n = 2'b00;
        @(posedge clk_kn); #1;
        wps_n = 1'b1;
        chk(pend_valid === 1'b0, "R7 no start on clk_kn", {35'd0, pend_valid}, 36'd0);
        @(posedge clk_kn); #1;
        chk(pend_valid === 1'b0, "R7 no start on clk_kn", {35'd0, pend_valid}, 36'd0);
        idle(8'd3);
        read_chk(8'd77, "R7 array untouched");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule